// File: doc/BRIEF.md
# Indexed Chipset Configuration Port

This block is a configuration register file for a chipset, reached through a pair of byte-wide I/O locations on an 8-bit bus. The bus presents only the lowest address bit to the block. A write with that bit clear loads a pointer. Accesses with that bit set reach the register the pointer names. The pointer stays where it was put: it does not advance after an access.

Every one of the pointer positions can be written. Reads are deliberately restricted. Only a fixed set of positions give back what was stored. Two identification positions return only some of their bits, and the rest read as zero. Any other position, and the pointer location itself, reads as all ones. A window of seven consecutive bytes, starting at position 0x09, is exported in parallel to the memory decoder. The decoder uses them to steer boot-area and low-memory regions.

Top module: `cfgport_top`

## Requirements
- R1: After reset the pointer is 0x00 and every stored byte is 0x00, so the exported window is all zeros and visible positions read 0x00.
- R2: A write with `io_a0`=0 loads `io_wdata` into the pointer at that clock edge. The pointer keeps its value across any number of data reads and writes, and never increments.
- R3: A write with `io_a0`=1 stores `io_wdata` into the byte selected by the pointer, for all 256 pointer values.
- R4: A data read (`io_a0`=1) with pointer 0x04 returns the stored byte ANDed with 0x1C, which clears bits 7, 6, 5, 1 and 0.
- R5: A data read with pointer 0x08 returns the stored byte ANDed with 0x1F, which clears bits 7 to 5.
- R6: A data read with pointer 0x05, 0x06, any of 0x09 through 0x13, or any of 0x28 through 0x2A returns the stored byte unchanged.
- R7: A data read with any other pointer value returns 0xFF. A read with `io_a0`=0 always returns 0xFF.
- R8: `cfg_map` bits [8k+7:8k] equal the stored byte at position 0x09+k, for k = 0 to 6. The window changes only on the edge after a data write.
- R9: `io_rdata` is a combinational view of the stored state. In a cycle where a data write hits the addressed byte, it shows the old value, and the new value appears from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_a0 | input | 1 | Low address bit: 0 selects the pointer, 1 selects the data byte |
| io_wr | input | 1 | Write strobe, sampled on the rising edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the location `io_a0` selects |
| cfg_map | output | 56 | Stored bytes 0x09 to 0x0F, lowest position in the lowest byte |

## Verification
The masking of the identification bytes is only visible when those bytes hold set bits in the positions being cleared. Hidden positions also have to be shown to store data even though they always read 0xFF. For these reasons the bench does not look at one register at a time. It fills every one of the 256 positions with an arithmetic pattern, then sweeps all of them back and predicts each read from the position class. It then repeats the fill with the complemented pattern, so that every bit of each masked byte is exercised both set and clear.

The hardest case to reach is a read and a write to the same byte in the same cycle. The bench reaches it by holding a data write strobe and sampling `io_rdata` before the edge. It then samples again one cycle later.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

   // Read classes for the data location.
   typedef enum logic [1:0] {
      RD_HIDDEN = 2'd0,
      RD_PLAIN  = 2'd1,
      RD_ID_LO  = 2'd2,
      RD_ID_HI  = 2'd3
   } rd_class_e;

   // Identification positions and the bits each one exposes.
   localparam int unsigned ID_LO_POS  = 32'h04;
   localparam int unsigned ID_HI_POS  = 32'h08;
   localparam logic [7:0]  ID_LO_KEEP = 8'h1C;
   localparam logic [7:0]  ID_HI_KEEP = 8'h1F;

   // Positions that read back unchanged.
   localparam int unsigned PLAIN_A_LO = 32'h05;
   localparam int unsigned PLAIN_A_HI = 32'h06;
   localparam int unsigned PLAIN_B_LO = 32'h09;
   localparam int unsigned PLAIN_B_HI = 32'h13;
   localparam int unsigned PLAIN_C_LO = 32'h28;
   localparam int unsigned PLAIN_C_HI = 32'h2A;

   // Highest position the read policy refers to.
   localparam int unsigned POLICY_TOP = PLAIN_C_HI;

   function automatic rd_class_e classify(input int unsigned pos);
      rd_class_e c;
      c = RD_HIDDEN;
      if (pos == ID_LO_POS)
         c = RD_ID_LO;
      else if (pos == ID_HI_POS)
         c = RD_ID_HI;
      else if ((pos >= PLAIN_A_LO && pos <= PLAIN_A_HI) ||
               (pos >= PLAIN_B_LO && pos <= PLAIN_B_HI) ||
               (pos >= PLAIN_C_LO && pos <= PLAIN_C_HI))
         c = RD_PLAIN;
      return c;
   endfunction

endpackage

// File: rtl/cfgport_index.sv
module cfgport_index #(
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [IDX_W-1:0]  idx_q
);

   generate
      if (DATA_W < IDX_W) begin : g_bad_width
         $error("cfgport_index: DATA_W must be at least IDX_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (load)
         idx_q <= din[IDX_W-1:0];
   end

endmodule

// File: rtl/cfgport_regfile.sv
module cfgport_regfile #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned IDX_W    = 8,
   parameter int unsigned MAP_BASE = 9,
   parameter int unsigned MAP_CNT  = 7
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [DATA_W-1:0]         wdata,
   input  logic [IDX_W-1:0]          rd_idx,
   output logic [DATA_W-1:0]         rd_word,
   output logic [MAP_CNT*DATA_W-1:0] map_out
);

   localparam int unsigned DEPTH = 1 << IDX_W;

   generate
      if (MAP_BASE + MAP_CNT > DEPTH) begin : g_bad_map
         $error("cfgport_regfile: export window exceeds register depth");
      end
      if (MAP_CNT == 0) begin : g_bad_cnt
         $error("cfgport_regfile: export window must be non-empty");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];

   // One enabled byte register per position.
   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         logic [DATA_W-1:0] ent_q;
         logic              hit;
         assign hit = wr_en && (wr_idx == IDX_W'(e));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ent_q <= '0;
            else if (hit)
               ent_q <= wdata;
         end
         assign mem[e] = ent_q;
      end
   endgenerate

   assign rd_word = mem[rd_idx];

   // Parallel export of the decoder window.
   generate
      for (genvar k = 0; k < MAP_CNT; k++) begin : g_map
         assign map_out[k*DATA_W +: DATA_W] = mem[MAP_BASE + k];
      end
   endgenerate

endmodule

// File: rtl/cfgport_rdfilter.sv
module cfgport_rdfilter
   import cfgport_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 8
) (
   input  logic              sel_data,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [DATA_W-1:0] KEEP_LO = DATA_W'(ID_LO_KEEP);
   localparam logic [DATA_W-1:0] KEEP_HI = DATA_W'(ID_HI_KEEP);

   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("cfgport_rdfilter: DATA_W must be at least 8");
      end
   endgenerate

   rd_class_e cls;

   always_comb begin
      cls = classify(int'(idx));
      if (!sel_data) begin
         rdata = '1;
      end else begin
         unique case (cls)
            RD_PLAIN:  rdata = word;
            RD_ID_LO:  rdata = word & KEEP_LO;
            RD_ID_HI:  rdata = word & KEEP_HI;
            default:   rdata = '1;
         endcase
      end
   end

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
   import cfgport_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned IDX_W    = 8,
   parameter int unsigned MAP_BASE = 9,
   parameter int unsigned MAP_CNT  = 7
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      io_a0,
   input  logic                      io_wr,
   input  logic [DATA_W-1:0]         io_wdata,
   output logic [DATA_W-1:0]         io_rdata,
   output logic [MAP_CNT*DATA_W-1:0] cfg_map
);

   localparam int unsigned DEPTH = 1 << IDX_W;

   generate
      if (DEPTH <= POLICY_TOP) begin : g_bad_depth
         $error("cfgport_top: IDX_W too small for the read policy");
      end
   endgenerate

   logic              idx_load;
   logic              data_wr;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] word;

   assign idx_load = io_wr && !io_a0;
   assign data_wr  = io_wr &&  io_a0;

   cfgport_index #(
      .IDX_W  (IDX_W),
      .DATA_W (DATA_W)
   ) u_index (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (idx_load),
      .din   (io_wdata),
      .idx_q (idx_q)
   );

   cfgport_regfile #(
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .MAP_BASE (MAP_BASE),
      .MAP_CNT  (MAP_CNT)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (data_wr),
      .wr_idx  (idx_q),
      .wdata   (io_wdata),
      .rd_idx  (idx_q),
      .rd_word (word),
      .map_out (cfg_map)
   );

   cfgport_rdfilter #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_filter (
      .sel_data (io_a0),
      .idx      (idx_q),
      .word     (word),
      .rdata    (io_rdata)
   );

endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned IDX_W    = 8,
   parameter int unsigned MAP_BASE = 9,
   parameter int unsigned MAP_CNT  = 7
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      io_a0,
   input logic                      io_wr,
   input logic [DATA_W-1:0]         io_wdata,
   input logic [DATA_W-1:0]         io_rdata,
   input logic [MAP_CNT*DATA_W-1:0] cfg_map,
   input logic [IDX_W-1:0]          idx_q
);

   logic in_win;
   int   win_off;
   assign in_win  = (int'(idx_q) >= int'(MAP_BASE)) &&
                    (int'(idx_q) <  int'(MAP_BASE + MAP_CNT));
   assign win_off = in_win ? int'(idx_q) - int'(MAP_BASE) : 0;

   // R2: pointer load on a write to the even location
   assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !io_a0) |=> (idx_q == $past(io_wdata[IDX_W-1:0])));

   // R2: pointer never moves otherwise
   assert_idx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && !io_a0) |=> $stable(idx_q));

   // R3 and R8: a data write into the window shows up on the export
   assert_map_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_a0 && in_win) |=>
         (cfg_map[$past(win_off)*DATA_W +: DATA_W] == $past(io_wdata)));

   // R8: window moves only after a data write
   assert_map_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_a0) |=> $stable(cfg_map));

   // R4: low identification byte has bits 7..5 and 1..0 clear
   assert_id_lo_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (io_a0 && idx_q == IDX_W'(4)) |-> ((io_rdata[7:0] & 8'hE3) == 8'h00));

   // R5: high identification byte has bits 7..5 clear
   assert_id_hi_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_a0 && idx_q == IDX_W'(8)) |-> ((io_rdata[7:0] & 8'hE0) == 8'h00));

   // R7: pointer location always reads all ones
   assert_idx_read_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !io_a0 |-> (io_rdata == '1));

   // R6: window bytes read back as exported
   assert_win_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (io_a0 && in_win) |-> (io_rdata == cfg_map[win_off*DATA_W +: DATA_W]));

endmodule

bind cfgport_top cfgport_checker #(
   .DATA_W   (DATA_W),
   .IDX_W    (IDX_W),
   .MAP_BASE (MAP_BASE),
   .MAP_CNT  (MAP_CNT)
) u_cfgport_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .io_a0    (io_a0),
   .io_wr    (io_wr),
   .io_wdata (io_wdata),
   .io_rdata (io_rdata),
   .cfg_map  (cfg_map),
   .idx_q    (idx_q)
);

// File: tb/cfgport_top_bench.sv
`timescale 1ns/1ps
module cfgport_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_a0 = 1'b0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_wdata = 8'h00;
   logic [7:0]  io_rdata;
   logic [55:0] cfg_map;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   cfgport_top u_cfgport_top (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_a0    (io_a0),
      .io_wr    (io_wr),
      .io_wdata (io_wdata),
      .io_rdata (io_rdata),
      .cfg_map  (cfg_map)
   );

   function automatic logic [7:0] pat(input int i, input bit inv);
      logic [7:0] v;
      v = 8'((i * 37 + 11) & 255);
      return inv ? ~v : v;
   endfunction

   // Expected data-location read from the requirements.
   function automatic logic [7:0] exp_read(input int i, input logic [7:0] v);
      if (i == 4)                              return v & 8'h1C;  // R4
      if (i == 8)                              return v & 8'h1F;  // R5
      if (i == 5 || i == 6)                    return v;          // R6
      if (i >= 9 && i <= 19)                   return v;          // R6
      if (i >= 40 && i <= 42)                  return v;          // R6
      return 8'hFF;                                               // R7
   endfunction

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic a0, input logic [7:0] d);
      @(negedge clk);
      io_a0 = a0; io_wr = 1'b1; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic a0, output logic [7:0] d);
      @(negedge clk);
      io_a0 = a0; io_wr = 1'b0;
      #1;
      d = io_rdata;
   endtask

   initial begin
      #1000000;
      bad++; total++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0]  r;
      logic [55:0] em;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1 map", cfg_map, 56'h0);
      rd(1'b1, r);
      chk("R1 idx0", r, 8'hFF);
      for (int i = 0; i < 256; i++) begin
         wr(1'b0, 8'(i));
         rd(1'b1, r);
         chk("R1 sweep", r, exp_read(i, 8'h00));
      end
      rd(1'b0, r);
      chk("R7 idxread", r, 8'hFF);

      // R3..R8: fill, sweep, then complemented fill
      for (int p = 0; p < 2; p++) begin
         for (int i = 0; i < 256; i++) begin
            wr(1'b0, 8'(i));
            wr(1'b1, pat(i, p[0]));
         end
         for (int i = 0; i < 256; i++) begin
            wr(1'b0, 8'(i));
            rd(1'b1, r);
            chk("R3 R4 R5 R6 R7 sweep", r, exp_read(i, pat(i, p[0])));
         end
         em = '0;
         for (int k = 0; k < 7; k++) em[k*8 +: 8] = pat(9 + k, p[0]);
         chk("R8 map", cfg_map, em);
      end

      // R2: pointer holds, no auto-increment
      wr(1'b0, 8'h10);
      wr(1'b1, 8'h3C);
      wr(1'b1, 8'hC3);
      rd(1'b1, r);
      chk("R2 hold", r, 8'hC3);
      rd(1'b1, r);
      chk("R2 again", r, 8'hC3);
      wr(1'b0, 8'h11);
      rd(1'b1, r);
      chk("R2 neighbour", r, pat(17, 1'b1));
      rd(1'b0, r);
      chk("R7 idxread vis", r, 8'hFF);

      // R9: same-cycle write and read
      wr(1'b0, 8'h28);
      @(negedge clk);
      io_a0 = 1'b1; io_wr = 1'b1; io_wdata = 8'h5A;
      #1;
      chk("R9 old", io_rdata, pat(40, 1'b1));
      @(negedge clk);
      io_wr = 1'b0;
      #1;
      chk("R9 new", io_rdata, 8'h5A);

      // R8: window updated by a single write at position 0x0F
      wr(1'b0, 8'h0F);
      wr(1'b1, 8'hA7);
      chk("R8 top byte", cfg_map[55:48], 8'hA7);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule